// File: doc/BRIEF.md
# Power Management Event Status Register

This block collects power management events into one 16-bit status word. Each implemented bit is sticky. Hardware sets it when its event occurs, and software clears it by writing a one to its position through a one-cycle write strobe. Events that have a level-sensitive source cannot be cleared while the source is still active.

The block also turns a latched timer overflow into an SMI or an SCI request, according to two enable inputs. The system sleep or on state arrives as an input. When an enabled wake event occurs during sleep, the block latches the wake status and pulses a wake request toward the power sequencer.

The status bits fall into three reset groups:
- A hard platform reset clears only the volatile bits.
- A resume-well reset also clears the wake, alarm and button bits.
- The RTC-well reset clears every bit, including the button override.

Top module: `pm_evt_status`

## Requirements
- R1: Bit 0 latches a timer overflow. While bit 0 is set and `tmr_en` is 1, `smi` is 1 when `sci_en` is 0, and `sci` is 1 when `sci_en` is 1. With `tmr_en` at 0, neither output is raised. Both outputs are registered levels, one cycle behind the status.
- R2: Bit 15, the wake status, is set by `wake_evt` or by a power button press only while `in_sleep` is 1. `wake_req` pulses for one cycle, in the same cycle that bit 15 first becomes 1.
- R3: A write with `wr_en` clears each status bit whose `wr_data` bit is 1 and leaves the others unchanged. If a hardware set and a software clear hit a bit in the same cycle, the bit ends up set.
- R4: Bit 14, the PCI Express wake status, cannot be cleared while any bit of `pcie_src` is 1.
- R5: Bit 14 is set only when some `pcie_src` bit is active while `in_sleep` is 1. It has no effect on `wake_req`.
- R6: A `power_return` pulse sets bit 15 only when `after_loss_cfg` is 1.
- R7: Each reset clears a different set of bits:
  - `rst_plt` clears bits 0, 13 and 14.
  - `rst_rsm` clears every bit except bit 11.
  - `rst_rtc` clears all bits.
- R8: An `rtc_alarm` pulse sets bit 10, and a `usb_evt` pulse sets bit 13, in either power state.
- R9: Bits 1 through 7, 9 and 12 always read 0.
- R10: Bit 8 is set on the falling edge of `pwrbtn_n`. Clearing it while the button is held does not set it again. After `OVR_CYCLES` consecutive low cycles, bit 11 is set and bit 8 is cleared. A `thermal_trip` pulse sets bit 11 and clears bit 8 in the same way.
- R11: While bit 11 is set and `sci_en` is 1, `sci` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_plt | input | 1 | Synchronous hard platform reset, active high |
| rst_rsm | input | 1 | Synchronous resume-well reset, active high |
| rst_rtc | input | 1 | Synchronous RTC-well reset, active high |
| in_sleep | input | 1 | 1 while the system is in a sleep state |
| wake_evt | input | 1 | Enabled wake event pulse |
| after_loss_cfg | input | 1 | Sets wake status when power returns |
| power_return | input | 1 | Pulse when power comes back after a loss |
| pcie_src | input | PCIE_SRCS | Level PCI Express wake sources (pins, beacon, PME received) |
| usb_evt | input | 1 | USB line change pulse |
| rtc_alarm | input | 1 | RTC alarm pulse |
| pwrbtn_n | input | 1 | Power button, low when pressed |
| thermal_trip | input | 1 | Catastrophic thermal pulse |
| tmr_ovf | input | 1 | Timer overflow pulse |
| tmr_en | input | 1 | Timer overflow interrupt enable |
| sci_en | input | 1 | Route to SCI instead of SMI |
| wr_en | input | 1 | Write-one-to-clear strobe |
| wr_data | input | 16 | Clear mask |
| status | output | 16 | Status word |
| smi | output | 1 | SMI request level |
| sci | output | 1 | SCI request level |
| wake_req | output | 1 | One-cycle request to move to the on state |

## Verification
The assertions assume the following about the inputs:
- All three resets are synchronous.
- Bit 11 can only rise through a long button press or a thermal trip.
- `OVR_CYCLES` is at least 2, so a press and an override never land on the same edge.

The stimulus changes inputs only on the falling clock edge and drives each event for a single cycle. It holds the button low for whole cycles and toggles the PCI Express sources as plain levels. The routing enables are swept through all four combinations while the status stays stable.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
  localparam int STS_W    = 16;
  localparam int BIT_TMR  = 0;
  localparam int BIT_PB   = 8;
  localparam int BIT_RTC  = 10;
  localparam int BIT_OVR  = 11;
  localparam int BIT_USB  = 13;
  localparam int BIT_PCIE = 14;
  localparam int BIT_WAKE = 15;
  localparam logic [STS_W-1:0] IMPL_MASK = 16'b1110_1101_0000_0001;

  typedef enum logic [1:0] {
    DOM_PLT = 2'd0,
    DOM_RSM = 2'd1,
    DOM_RTC = 2'd2
  } rst_dom_e;

  function automatic rst_dom_e bit_domain(input int idx);
    if (idx == BIT_OVR) return DOM_RTC;
    if (idx == BIT_WAKE || idx == BIT_PB || idx == BIT_RTC) return DOM_RSM;
    return DOM_PLT;
  endfunction
endpackage

// File: rtl/pm_w1c_bit.sv
module pm_w1c_bit (
  input  logic clk,
  input  logic rst,
  input  logic hw_set,
  input  logic hw_clr,
  input  logic sw_clr,
  input  logic clr_hold,
  output logic q
);
  // Order of priority: reset, forced hardware clear, hardware set, software clear.
  always_ff @(posedge clk) begin
    if (rst)                        q <= 1'b0;
    else if (hw_clr)                q <= 1'b0;
    else if (hw_set)                q <= 1'b1;
    else if (sw_clr && !clr_hold)   q <= 1'b0;
  end
endmodule

// File: rtl/pm_pwrbtn_mon.sv
module pm_pwrbtn_mon #(
  parameter int OVR_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_n,
  output logic press,
  output logic long_evt
);
  localparam int CW = $clog2(OVR_CYCLES + 1);
  localparam logic [CW-1:0] CNT_MAX  = CW'(OVR_CYCLES);
  localparam logic [CW-1:0] CNT_LAST = CW'(OVR_CYCLES - 1);

  logic          prev_n;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_n <= 1'b1;
      cnt    <= '0;
    end else begin
      prev_n <= btn_n;
      if (btn_n)               cnt <= '0;
      else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end
  end

  assign press    = prev_n & ~btn_n;
  assign long_evt = ~btn_n & (cnt == CNT_LAST);
endmodule

// File: rtl/pm_evt_route.sv
module pm_evt_route (
  input  logic clk,
  input  logic rst,
  input  logic tmr_sts,
  input  logic ovr_sts,
  input  logic tmr_en,
  input  logic sci_en,
  output logic smi,
  output logic sci
);
  always_ff @(posedge clk) begin
    if (rst) begin
      smi <= 1'b0;
      sci <= 1'b0;
    end else begin
      smi <= tmr_sts & tmr_en & ~sci_en;
      sci <= sci_en & ((tmr_sts & tmr_en) | ovr_sts);
    end
  end
endmodule

// File: rtl/pm_evt_status.sv
module pm_evt_status #(
  parameter int PCIE_SRCS  = 4,
  parameter int OVR_CYCLES = 1000
) (
  input  logic                 clk,
  input  logic                 rst_plt,
  input  logic                 rst_rsm,
  input  logic                 rst_rtc,
  input  logic                 in_sleep,
  input  logic                 wake_evt,
  input  logic                 after_loss_cfg,
  input  logic                 power_return,
  input  logic [PCIE_SRCS-1:0] pcie_src,
  input  logic                 usb_evt,
  input  logic                 rtc_alarm,
  input  logic                 pwrbtn_n,
  input  logic                 thermal_trip,
  input  logic                 tmr_ovf,
  input  logic                 tmr_en,
  input  logic                 sci_en,
  input  logic                 wr_en,
  input  logic [15:0]          wr_data,
  output logic [15:0]          status,
  output logic                 smi,
  output logic                 sci,
  output logic                 wake_req
);
  import pm_evt_pkg::*;

  logic rst_any, rst_rsw;
  logic pb_press, pb_long, ovr_evt;
  logic pcie_act, pcie_set, wake_set;
  logic [STS_W-1:0] set_v, hclr_v, hold_v, clr_v, sts_raw;
  logic [2:0]       dom_rst;

  assign rst_any = rst_plt | rst_rsm | rst_rtc;
  assign rst_rsw = rst_rsm | rst_rtc;
  assign dom_rst = {rst_rtc, rst_rsw, rst_any};

  pm_pwrbtn_mon #(.OVR_CYCLES(OVR_CYCLES)) u_btn (
    .clk(clk), .rst(rst_rsw), .btn_n(pwrbtn_n),
    .press(pb_press), .long_evt(pb_long)
  );

  assign ovr_evt  = pb_long | thermal_trip;
  assign pcie_act = |pcie_src;
  assign pcie_set = in_sleep & pcie_act;
  assign wake_set = (in_sleep & (wake_evt | pb_press)) |
                    (power_return & after_loss_cfg);
  assign clr_v    = wr_en ? wr_data : '0;

  always_comb begin
    set_v  = '0;
    hclr_v = '0;
    hold_v = '0;
    set_v[BIT_TMR]  = tmr_ovf;
    set_v[BIT_PB]   = pb_press;
    set_v[BIT_RTC]  = rtc_alarm;
    set_v[BIT_OVR]  = ovr_evt;
    set_v[BIT_USB]  = usb_evt;
    set_v[BIT_PCIE] = pcie_set;
    set_v[BIT_WAKE] = wake_set;
    hclr_v[BIT_PB]  = ovr_evt;
    hold_v[BIT_PCIE] = pcie_act;
  end

  for (genvar i = 0; i < STS_W; i++) begin : g_bit
    localparam rst_dom_e DOM = bit_domain(i);
    pm_w1c_bit u_bit (
      .clk(clk), .rst(dom_rst[DOM]), .hw_set(set_v[i]), .hw_clr(hclr_v[i]),
      .sw_clr(clr_v[i]), .clr_hold(hold_v[i]), .q(sts_raw[i])
    );
  end

  assign status = sts_raw & IMPL_MASK;

  always_ff @(posedge clk) begin
    if (rst_rsw) wake_req <= 1'b0;
    else         wake_req <= wake_set & ~sts_raw[BIT_WAKE];
  end

  pm_evt_route u_route (
    .clk(clk), .rst(rst_any), .tmr_sts(status[BIT_TMR]), .ovr_sts(status[BIT_OVR]),
    .tmr_en(tmr_en), .sci_en(sci_en), .smi(smi), .sci(sci)
  );
endmodule

// File: rtl/pm_evt_status_chk.sv
module pm_evt_status_chk #(
  parameter int PCIE_SRCS = 4
) (
  input logic                 clk,
  input logic                 rst_any,
  input logic                 in_sleep,
  input logic [PCIE_SRCS-1:0] pcie_src,
  input logic                 tmr_en,
  input logic                 sci_en,
  input logic [15:0]          status,
  input logic                 smi,
  input logic                 sci,
  input logic                 wake_req
);
  AST_SMI_SCI_EXCL: assert property (@(posedge clk) disable iff (rst_any) !(smi && sci)); // R1
  AST_SMI_ROUTE: assert property (@(posedge clk) disable iff (rst_any)
    !$past(rst_any) |-> (smi == $past(status[0] && tmr_en && !sci_en))); // R1
  AST_WAKE_REQ_STS: assert property (@(posedge clk) disable iff (rst_any)
    wake_req |-> status[15]); // R2
  AST_PCIE_HOLD: assert property (@(posedge clk) disable iff (rst_any)
    (status[14] && (|pcie_src)) |=> status[14]); // R4
  AST_PCIE_AWAKE: assert property (@(posedge clk) disable iff (rst_any)
    (!in_sleep && !status[14]) |=> !status[14]); // R5
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst_any)
    (status[12] == 1'b0) && (status[9] == 1'b0) && (status[7:1] == 7'd0)); // R9
  AST_OVR_CLR_PB: assert property (@(posedge clk) disable iff (rst_any)
    $rose(status[11]) |-> !status[8]); // R10
endmodule

bind pm_evt_status pm_evt_status_chk #(.PCIE_SRCS(PCIE_SRCS)) u_chk (
  .clk(clk), .rst_any(rst_any), .in_sleep(in_sleep), .pcie_src(pcie_src),
  .tmr_en(tmr_en), .sci_en(sci_en), .status(status), .smi(smi), .sci(sci),
  .wake_req(wake_req)
);

// File: tb/pm_evt_status_bench.sv
`timescale 1ns/1ps
module pm_evt_status_bench;
  localparam int NS  = 4;
  localparam int OVR = 8;

  logic clk = 1'b0;
  logic rst_plt, rst_rsm, rst_rtc, in_sleep, wake_evt, after_loss_cfg, power_return;
  logic [NS-1:0] pcie_src;
  logic usb_evt, rtc_alarm, pwrbtn_n, thermal_trip, tmr_ovf, tmr_en, sci_en, wr_en;
  logic [15:0] wr_data, status;
  logic smi, sci, wake_req;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pm_evt_status #(.PCIE_SRCS(NS), .OVR_CYCLES(OVR)) u_pm_evt_status (
    .clk(clk), .rst_plt(rst_plt), .rst_rsm(rst_rsm), .rst_rtc(rst_rtc),
    .in_sleep(in_sleep), .wake_evt(wake_evt), .after_loss_cfg(after_loss_cfg),
    .power_return(power_return), .pcie_src(pcie_src), .usb_evt(usb_evt),
    .rtc_alarm(rtc_alarm), .pwrbtn_n(pwrbtn_n), .thermal_trip(thermal_trip),
    .tmr_ovf(tmr_ovf), .tmr_en(tmr_en), .sci_en(sci_en), .wr_en(wr_en),
    .wr_data(wr_data), .status(status), .smi(smi), .sci(sci), .wake_req(wake_req)
  );

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wclr(input logic [15:0] m);
    wr_en = 1'b1; wr_data = m; tick(); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic fill_all();
    in_sleep = 1'b1;
    thermal_trip = 1'b1; tick(); thermal_trip = 1'b0;
    pwrbtn_n = 1'b0; tick(); pwrbtn_n = 1'b1; tick();
    pcie_src = 4'b0001; tick(); pcie_src = '0;
    usb_evt = 1'b1; rtc_alarm = 1'b1; tmr_ovf = 1'b1; tick();
    usb_evt = 1'b0; rtc_alarm = 1'b0; tmr_ovf = 1'b0;
    in_sleep = 1'b0;
  endtask

  initial begin
    rst_plt = 1; rst_rsm = 1; rst_rtc = 1; in_sleep = 0; wake_evt = 0;
    after_loss_cfg = 0; power_return = 0; pcie_src = '0; usb_evt = 0;
    rtc_alarm = 0; pwrbtn_n = 1; thermal_trip = 0; tmr_ovf = 0; tmr_en = 0;
    sci_en = 0; wr_en = 0; wr_data = '0;
    @(negedge clk); tick(); tick();
    rst_plt = 0; rst_rsm = 0; rst_rtc = 0;
    tick();
    chk("R7 reset status", status, 16'h0000);
    chk("R7 reset outputs", {13'd0, smi, sci, wake_req}, 16'h0000);

    // R1: all four enable combinations
    for (int e = 0; e < 2; e++) begin
      for (int s = 0; s < 2; s++) begin
        tmr_en = e[0]; sci_en = s[0];
        tmr_ovf = 1'b1; tick(); tmr_ovf = 1'b0;
        chk("R1 tmr status", status, 16'h0001);
        tick();
        chk("R1 smi", {15'd0, smi}, {15'd0, e[0] & ~s[0]});
        chk("R1 sci", {15'd0, sci}, {15'd0, e[0] & s[0]});
        wclr(16'h0001); tick();
        chk("R1 drop", {14'd0, smi, sci}, 16'h0000);
      end
    end
    tmr_en = 0; sci_en = 0;

    // R3: write 0 keeps, set beats clear
    tmr_ovf = 1'b1; tick(); tmr_ovf = 1'b0;
    wclr(16'h0000);
    chk("R3 zero write keeps", status, 16'h0001);
    tmr_ovf = 1'b1; wr_en = 1'b1; wr_data = 16'h0001; tick();
    tmr_ovf = 1'b0; wr_en = 1'b0; wr_data = '0;
    chk("R3 set wins", status, 16'h0001);
    wclr(16'hFFFF);

    // R3 R9: fill then clear one bit at a time
    fill_all();
    begin
      logic [15:0] exp;
      exp = 16'hED01;
      chk("R9 filled", status, exp);
      for (int i = 0; i < 16; i++) begin
        wclr(16'(1 << i));
        exp = exp & ~(16'(1 << i));
        chk("R3 R9 bit clear", status, exp);
      end
    end

    // R5 R4: PCI Express wake
    pcie_src = 4'b0100; tick();
    chk("R5 awake no set", status, 16'h0000);
    in_sleep = 1'b1; tick();
    chk("R5 sleep set", status, 16'h4000);
    chk("R5 no wake req", {15'd0, wake_req}, 16'h0000);
    in_sleep = 1'b0;
    wclr(16'h4000);
    chk("R4 clear blocked", status, 16'h4000);
    pcie_src = '0; tick();
    wclr(16'h4000);
    chk("R4 clear after release", status, 16'h0000);

    // R2: wake rules
    wake_evt = 1'b1; tick(); wake_evt = 1'b0;
    chk("R2 awake ignored", status, 16'h0000);
    in_sleep = 1'b1; wake_evt = 1'b1; tick(); wake_evt = 1'b0; in_sleep = 1'b0;
    chk("R2 sleep wake", status, 16'h8000);
    chk("R2 wake_req pulse", {15'd0, wake_req}, 16'h0001);
    tick();
    chk("R2 wake_req end", {15'd0, wake_req}, 16'h0000);
    wclr(16'h8000);

    // R6: power return
    power_return = 1'b1; tick(); power_return = 1'b0;
    chk("R6 cfg0", status, 16'h0000);
    after_loss_cfg = 1'b1; power_return = 1'b1; tick(); power_return = 1'b0;
    after_loss_cfg = 1'b0;
    chk("R6 cfg1", status, 16'h8000);
    wclr(16'h8000);

    // R8: alarm and USB while awake
    rtc_alarm = 1'b1; tick(); rtc_alarm = 1'b0;
    chk("R8 rtc", status, 16'h0400);
    usb_evt = 1'b1; tick(); usb_evt = 1'b0;
    chk("R8 usb", status, 16'h2400);
    wclr(16'hFFFF);

    // R10: button press, held clear, override
    pwrbtn_n = 1'b0; tick();
    chk("R10 press", status, 16'h0100);
    wclr(16'h0100);
    chk("R10 held clear", status, 16'h0000);
    for (int k = 3; k <= OVR - 1; k++) tick();
    chk("R10 before override", status, 16'h0000);
    tick();
    chk("R10 override", status, 16'h0800);
    pwrbtn_n = 1'b1; tick();
    // R11
    sci_en = 1'b1; tick();
    chk("R11 ovr sci", {14'd0, smi, sci}, 16'h0001);
    sci_en = 1'b0;
    wclr(16'h0800);
    pwrbtn_n = 1'b0; tick(); pwrbtn_n = 1'b1;
    thermal_trip = 1'b1; tick(); thermal_trip = 1'b0;
    chk("R10 thermal", status, 16'h0800);
    wclr(16'hFFFF);

    // R7: reset domains
    fill_all();
    rst_plt = 1'b1; tick(); rst_plt = 1'b0;
    chk("R7 hard reset", status, 16'h8D00);
    rst_rsm = 1'b1; tick(); rst_rsm = 1'b0;
    chk("R7 resume reset", status, 16'h0800);
    rst_rtc = 1'b1; tick(); rst_rtc = 1'b0;
    chk("R7 rtc reset", status, 16'h0000);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule